// File: doc/BRIEF.md
# Set/Clear Multicore Mailbox Array

The block stores a bank of 32-bit message words, a fixed number per core, so that cores can signal one another. Software reaches the words over a simple 32-bit register bus through two address windows that map the same storage. A write to the first window ORs its data into the addressed word. A write to the second window clears each bit of the addressed word where the data holds a one. Reads from the second window return the stored word. Reads from the first window return zero.

Each word has a flag output that is high while the word holds any nonzero bit. These flags go to an interrupt router, and the router applies any enables and steering. Flag bit c*NPER + n is word n of core c, and it drives source n of that core. With the default parameters there are four cores, each with four words. The set window covers bytes 0x80 to 0xBF and the clear window covers 0xC0 to 0xFF. Word k sits at byte offset 4*k inside each window.

Top module: `mbox_array`

## Requirements
- R1: While reset is asserted, and after it is released, every word reads zero and every flag is low. Asserting reset in the middle of operation clears every word.
- R2: A full-width write to address SET_BASE + 4*k, which is 0x80 + 4*k by default, ORs the write data into word k. The result is visible from the clock edge that completes the write.
- R3: A full-width write to address CLR_BASE + 4*k, which is 0xC0 + 4*k by default, clears each bit of word k that is 1 in the write data. Bits that are 0 in the write data are left unchanged.
- R4: When the read strobe is high and the address lies in the clear window, read data shows word k in the same cycle, without a register stage.
- R5: Read data is zero when the read strobe is low, when the address lies in the set window, and when the address lies outside both windows.
- R6: Flag bit c*NPER + n is high exactly when word n of core c is nonzero. It follows the stored value from the edge at which a write takes effect.
- R7: A write whose byte enables are not all ones (all ones is 4'hF) leaves every word unchanged.
- R8: A write outside both windows leaves every word unchanged. Address bits [1:0] are ignored when a word is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe |
| addr | input | AW (8) | Byte address |
| wdata | input | DW (32) | Write data |
| wbe | input | DW/8 (4) | Byte enables; a write counts only when all are set |
| rdata | output | DW (32) | Read data, combinational |
| nonzero | output | NCORE*NPER (16) | Per-word nonzero flags |

## Verification
The bench builds the block with its default parameters: four cores, four words per core, and an 8-bit address that starts the set window at 0x80. Under these values both windows fill the upper half of the address space exactly. That brings into reach the last word at 0xFC, addresses below 0x80 that miss both windows, and the edge between the two windows at 0xBC and 0xC0. A long random sequence of reads and writes is mixed with directed steps that cover partial byte enables, unaligned addresses, and a reset in mid-run. The output is compared with a behavioural word-array model on every cycle.

// File: rtl/mbox_array.sv
module mbox_array #(
  parameter int NCORE    = 4,
  parameter int NPER     = 4,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int SET_BASE = 'h80
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [AW-1:0]          addr,
  input  logic [DW-1:0]          wdata,
  input  logic [DW/8-1:0]        wbe,
  output logic [DW-1:0]          rdata,
  output logic [NCORE*NPER-1:0]  nonzero
);
  localparam int NMB      = NCORE * NPER;
  localparam int IW       = $clog2(NMB);
  localparam int WIN      = NMB * 4;
  localparam int CLR_BASE = SET_BASE + WIN;
  localparam int TOP      = CLR_BASE + WIN;

  logic [DW-1:0] word [NMB];
  logic [AW:0]   a_ext;
  logic [IW-1:0] idx;
  logic          in_set, in_clr, wr_ok;

  assign a_ext  = {1'b0, addr};
  assign in_set = (a_ext >= (AW+1)'(SET_BASE)) && (a_ext < (AW+1)'(CLR_BASE));
  assign in_clr = (a_ext >= (AW+1)'(CLR_BASE)) && (a_ext < (AW+1)'(TOP));
  // windows are aligned to their size, so the word index is a plain slice
  assign idx    = addr[IW+1:2];
  assign wr_ok  = wr_en && (&wbe);

  for (genvar i = 0; i < NMB; i++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        word[i] <= '0;
      else if (wr_ok && idx == IW'(i)) begin
        if (in_set)
          word[i] <= word[i] | wdata;
        else if (in_clr)
          word[i] <= word[i] & ~wdata;
      end
    end
    assign nonzero[i] = |word[i];
  end

  assign rdata = (rd_en && in_clr) ? word[idx] : '0;
endmodule

// File: rtl/mbox_array_chk.sv
module mbox_array_chk #(
  parameter int NMB      = 16,
  parameter int DW       = 32,
  parameter int AW       = 8,
  parameter int SET_BASE = 'h80
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic            rd_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wdata,
  input logic [DW/8-1:0] wbe,
  input logic [DW-1:0]   rdata,
  input logic [NMB-1:0]  nonzero
);
  localparam int IW       = $clog2(NMB);
  localparam int CLR_BASE = SET_BASE + NMB * 4;
  localparam int TOP      = CLR_BASE + NMB * 4;

  logic [IW-1:0] k;
  logic          s_win, c_win;
  assign k     = addr[IW+1:2];
  assign s_win = (int'(addr) >= SET_BASE) && (int'(addr) < CLR_BASE);
  assign c_win = (int'(addr) >= CLR_BASE) && (int'(addr) < TOP);

  p_set_flags_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wbe) && s_win && wdata != '0) |=> nonzero[$past(k)]);

  p_clear_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (&wbe) && c_win && (&wdata)) |=> !nonzero[$past(k)]);

  p_read_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && c_win) |-> ((rdata != '0) == nonzero[k]));

  p_set_read_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || !c_win) |-> (rdata == '0));

  p_partial_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !(&wbe)) |=> $stable(nonzero));

  p_outside_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_win && !c_win) |=> $stable(nonzero));
endmodule

bind mbox_array mbox_array_chk #(
  .NMB(NCORE*NPER), .DW(DW), .AW(AW), .SET_BASE(SET_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .wbe(wbe), .rdata(rdata), .nonzero(nonzero)
);

// File: tb/sim_mbox_array.sv
module sim_mbox_array;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wbe = 0;
  logic [31:0] rdata;
  logic [15:0] nonzero;

  int checks = 0, failures = 0;
  logic [31:0] m [16];

  always #4 clk = ~clk;

  mbox_array u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .wbe(wbe), .rdata(rdata), .nonzero(nonzero));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, addr, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_flags();
    logic [15:0] f;
    for (int i = 0; i < 16; i++) f[i] = (m[i] != 0);
    return f;
  endfunction

  // drives one cycle, checks outputs mid-cycle, then updates the model at the edge
  task automatic step(string req, bit we, bit re, logic [7:0] a,
                      logic [31:0] d, logic [3:0] be);
    logic [31:0] er;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; wbe = be;
    #1;
    er = (re && a >= 8'hC0) ? m[a[5:2]] : 32'h0;
    check(req, rdata, er);
    check("R6", {16'h0, nonzero}, {16'h0, exp_flags()});
    @(posedge clk);
    if (rst_n && we && be == 4'hF) begin
      if (a >= 8'h80 && a < 8'hC0) m[a[5:2]] = m[a[5:2]] | d;
      else if (a >= 8'hC0) m[a[5:2]] = m[a[5:2]] & ~d;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    @(posedge clk); @(posedge clk);
    for (int i = 0; i < 16; i++) m[i] = 0;
    @(negedge clk);
    check("R1", {16'h0, nonzero}, 32'h0);
    rst_n = 1;
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 0;
    do_reset();
    for (int i = 0; i < 16; i++) step("R1", 0, 1, 8'(8'hC0 + 4*i), 0, 0);
    // set window ORs data
    step("R2", 1, 0, 8'h80, 32'h0000_00F0, 4'hF);
    step("R2", 1, 0, 8'h80, 32'h0000_000F, 4'hF);
    step("R4", 0, 1, 8'hC0, 0, 0);
    step("R2", 1, 0, 8'hBC, 32'h8000_0000, 4'hF);
    step("R4", 0, 1, 8'hFC, 0, 0);
    // set window and strobe-low reads are zero
    step("R5", 0, 1, 8'h80, 0, 0);
    step("R5", 0, 0, 8'hC0, 0, 0);
    step("R5", 0, 1, 8'h10, 0, 0);
    // clear only selected bits
    step("R3", 1, 0, 8'hC0, 32'h0000_0030, 4'hF);
    step("R3", 0, 1, 8'hC0, 0, 0);
    step("R3", 1, 0, 8'hC0, 32'hFFFF_FFFF, 4'hF);
    step("R3", 0, 1, 8'hC0, 0, 0);
    // partial byte enables ignored
    step("R7", 1, 0, 8'h84, 32'h1234_5678, 4'h7);
    step("R7", 1, 0, 8'hFC, 32'hFFFF_FFFF, 4'h1);
    step("R7", 0, 1, 8'hC4, 0, 0);
    step("R7", 0, 1, 8'hFC, 0, 0);
    // outside windows and low address bits
    step("R8", 1, 0, 8'h40, 32'hFFFF_FFFF, 4'hF);
    step("R8", 1, 0, 8'h7C, 32'hFFFF_FFFF, 4'hF);
    step("R8", 1, 0, 8'h8B, 32'h0000_0A00, 4'hF);
    step("R8", 0, 1, 8'hCA, 0, 0);
    step("R8", 0, 1, 8'hC8, 0, 0);
    // random traffic
    for (int n = 0; n < 2000; n++) begin
      logic [7:0] a;
      logic [3:0] be;
      a  = 8'($urandom_range(0, 255));
      if ($urandom_range(0, 3) != 0) a[7] = 1'b1;
      be = ($urandom_range(0, 7) == 0) ? 4'($urandom) : 4'hF;
      step("R4", $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, a,
           ($urandom_range(0, 1) == 1) ? $urandom : (32'h1 << $urandom_range(0, 31)), be);
    end
    // fill everything, then reset mid-run
    for (int i = 0; i < 16; i++) step("R2", 1, 0, 8'(8'h80 + 4*i), 32'hA5A5_0001, 4'hF);
    do_reset();
    for (int i = 0; i < 16; i++) step("R1", 0, 1, 8'(8'hC0 + 4*i), 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule